// File: doc/BRIEF.md
# Exponential Back-off Lock Requester

This block acquires a shared lock on behalf of one processor. The lock lives behind a port that accepts three operations: a load-linked read, a conditional store, and a plain store. After a request, the block spins on load-linked reads for as long as the lock value is nonzero. When a read returns zero, it tries a conditional store of the locked value. If that store succeeds, the lock is held and `acquired` rises. If it fails, the block stays quiet for a back-off interval before it reads again, and that interval doubles after every failure.

No delay is applied before the first attempt, so an uncontended lock costs only two round trips. The interval restarts at its initial value for every new acquisition and never grows past `MAX_DELAY`. Competing requesters can be spread apart by turning on `RAND_INIT`. With that option, a per-instance LFSR whose seed is a parameter adds a small random offset to the initial interval. A release request writes zero to the lock with one plain store and returns the block to idle.

The lock port carries one command at a time. A command is valid for exactly one cycle and then waits for a one-cycle response pulse. Operation codes on `cmd_op` are: 0 load-linked, 1 conditional store, 2 plain store.

Top module: `lock_backoff_req`

## Requirements
- R1: After reset, `acquired` and `cmd_valid` are low and the block is idle.
- R2: A cycle with `acq_req` high while idle causes a load-linked command (`cmd_op`=0) in the very next cycle, with no delay before this first attempt.
- R3: A load-linked response with nonzero `rsp_rdata` causes another load-linked command in the cycle right after the response, with no back-off.
- R4: A load-linked response with `rsp_rdata`=0 causes a conditional store (`cmd_op`=1) with `cmd_wdata`=`LOCK_VAL` in the cycle right after the response.
- R5: A conditional-store response with `rsp_sc_ok`=1 raises `acquired` in the next cycle. `acquired` then stays high until a release.
- R6: After a failed conditional store, the interval doubles, starting from 1, so the first pause is 2, then 4, then 8. The block then issues exactly that many idle cycles, with no command, beyond the normal response cycle before the next load-linked.
- R7: The interval saturates at `MAX_DELAY` and never exceeds it.
- R8: Each new acquisition restarts the interval at its initial value.
- R9: `rel_req` while held drops `acquired` and issues one plain store (`cmd_op`=2) of zero in the next cycle. After the store's response the block is idle and accepts a new request.
- R10: `rel_req` when not held has no effect, and `acq_req` when not idle has no effect. No extra command is issued in either case.
- R11: With `RAND_INIT`=1, the initial interval is 1 plus a value in [0, 2^`RAND_BITS`−1]. The first pause therefore lies in the even range [2, 2^(`RAND_BITS`+1)].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| acq_req | input | 1 | Request to acquire the lock (sampled while idle) |
| rel_req | input | 1 | Request to release the lock (sampled while held) |
| acquired | output | 1 | High while the lock is held |
| cmd_valid | output | 1 | One-cycle command strobe to the lock port |
| cmd_op | output | 2 | 0 load-linked, 1 conditional store, 2 plain store |
| cmd_wdata | output | DATA_W | Store data |
| rsp_valid | input | 1 | One-cycle response strobe |
| rsp_rdata | input | DATA_W | Lock value returned by a load-linked |
| rsp_sc_ok | input | 1 | Conditional store succeeded |

## Verification
The lock model is driven in several ways:
- A lock that is free at once separates the no-delay first attempt from any back-off path.
- A lock that reads as held for several polls shows that re-reads carry no pause.
- A run of failed conditional stores exposes the doubling sequence.
- A long run of failures shows saturation.
- A short acquisition straight after a long one shows that the interval restarts.

Stray acquire and release pulses are injected while polling and while held, which separates a correct ignore from a spurious command. A second instance with randomized start checks that the first pause falls in its allowed even range.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  typedef enum logic [1:0] {
    OP_LL = 2'd0,
    OP_SC = 2'd1,
    OP_ST = 2'd2
  } lock_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_LL_ISS,
    S_LL_WAIT,
    S_SC_ISS,
    S_SC_WAIT,
    S_BACKOFF,
    S_HELD,
    S_REL_ISS,
    S_REL_WAIT
  } req_state_e;
endpackage

// File: rtl/lbr_lfsr.sv
module lbr_lfsr #(
  parameter int          W     = 8,
  parameter int          OUT_W = 2,
  parameter logic [W-1:0] SEED = 8'hA5,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [OUT_W-1:0] rnd_o
);
  // a zero seed would lock the register, so force a nonzero one
  localparam logic [W-1:0] SEED_NZ = (SEED == '0) ? W'(1) : SEED;

  logic [W-1:0] s_q, s_d;

  always_comb begin
    s_d = {s_q[W-2:0], ^(s_q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= SEED_NZ;
    else if (en) s_q <= s_d;
  end

  assign rnd_o = s_q[OUT_W-1:0];
endmodule

// File: rtl/lbr_backoff.sv
module lbr_backoff #(
  parameter int MAX_DELAY = 64,
  parameter int DLY_W     = $clog2(MAX_DELAY) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_init,
  input  logic [DLY_W-1:0] init_val,
  input  logic             fail,
  input  logic             tick,
  output logic             expire,
  output logic [DLY_W-1:0] dly_o
);
  localparam logic [DLY_W:0] MAX_W = (DLY_W + 1)'(MAX_DELAY);

  logic [DLY_W-1:0] dly_q, dly_d, cnt_q, cnt_d, dbl_sat;
  logic [DLY_W:0]   dbl_w;
  logic             en;

  always_comb begin
    dbl_w   = {dly_q, 1'b0};
    dbl_sat = (dbl_w > MAX_W) ? MAX_W[DLY_W-1:0] : dbl_w[DLY_W-1:0];
    dly_d   = dly_q;
    cnt_d   = cnt_q;
    if (load_init) begin
      dly_d = init_val;
    end else if (fail) begin
      dly_d = dbl_sat;
      cnt_d = dbl_sat;
    end else if (tick && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign en = load_init | fail | tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      dly_q <= dly_d;
      cnt_q <= cnt_d;
    end
  end

  assign expire = (cnt_q == DLY_W'(1));
  assign dly_o  = dly_q;
endmodule

// File: rtl/lock_backoff_req.sv
module lock_backoff_req
  import lbr_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          LOCK_VAL  = 1,
  parameter int          MAX_DELAY = 64,
  parameter bit          RAND_INIT = 1'b0,
  parameter int          RAND_BITS = 2,
  parameter int          LFSR_W    = 8,
  parameter logic [7:0]  LFSR_SEED = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_req,
  input  logic              rel_req,
  output logic              acquired,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  input  logic              rsp_sc_ok
);
  localparam int DLY_W = $clog2(MAX_DELAY) + 1;

  req_state_e       state_q, state_d;
  logic             load_init, fail, tick, expire;
  logic [DLY_W-1:0] init_val, dly_w;

  generate
    if (RAND_INIT) begin : g_rand
      logic [RAND_BITS-1:0] rnd;
      lbr_lfsr #(
        .W(LFSR_W), .OUT_W(RAND_BITS),
        .SEED(LFSR_W'(LFSR_SEED)), .TAPS(LFSR_W'(8'hB8))
      ) u_lfsr (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .rnd_o(rnd)
      );
      assign init_val = DLY_W'(1) + DLY_W'(rnd);
    end else begin : g_fixed
      assign init_val = DLY_W'(1);
    end
  endgenerate

  lbr_backoff #(.MAX_DELAY(MAX_DELAY), .DLY_W(DLY_W)) u_backoff (
    .clk(clk), .rst_n(rst_n), .load_init(load_init), .init_val(init_val),
    .fail(fail), .tick(tick), .expire(expire), .dly_o(dly_w)
  );

  always_comb begin
    state_d   = state_q;
    load_init = 1'b0;
    fail      = 1'b0;
    tick      = 1'b0;
    cmd_valid = 1'b0;
    cmd_op    = OP_LL;
    cmd_wdata = '0;
    case (state_q)
      S_IDLE: if (acq_req) begin
        load_init = 1'b1;
        state_d   = S_LL_ISS;
      end
      S_LL_ISS: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_LL;
        state_d   = S_LL_WAIT;
      end
      S_LL_WAIT: if (rsp_valid) begin
        state_d = (rsp_rdata == '0) ? S_SC_ISS : S_LL_ISS;
      end
      S_SC_ISS: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_SC;
        cmd_wdata = DATA_W'(LOCK_VAL);
        state_d   = S_SC_WAIT;
      end
      S_SC_WAIT: if (rsp_valid) begin
        if (rsp_sc_ok) begin
          state_d = S_HELD;
        end else begin
          fail    = 1'b1;
          state_d = S_BACKOFF;
        end
      end
      S_BACKOFF: begin
        tick = 1'b1;
        if (expire) state_d = S_LL_ISS;
      end
      S_HELD: if (rel_req) state_d = S_REL_ISS;
      S_REL_ISS: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_ST;
        state_d   = S_REL_WAIT;
      end
      S_REL_WAIT: if (rsp_valid) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign acquired = (state_q == S_HELD);
endmodule

// File: rtl/lbr_checker.sv
module lbr_checker
  import lbr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LOCK_VAL  = 1,
  parameter int MAX_DELAY = 64,
  parameter int DLY_W     = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acquired,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [DATA_W-1:0] cmd_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_sc_ok,
  input logic [DLY_W-1:0]  dly
);
  logic [1:0] last_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_op <= 2'd3;
    else if (cmd_valid) last_op <= cmd_op;
  end

  p_single_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  p_reread_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && last_op == OP_LL && rsp_rdata != '0) |=> (cmd_valid && cmd_op == OP_LL));

  p_sc_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && last_op == OP_LL && rsp_rdata == '0)
      |=> (cmd_valid && cmd_op == OP_SC && cmd_wdata == DATA_W'(LOCK_VAL)));

  p_acq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acquired) |-> $past(rsp_valid && rsp_sc_ok && last_op == OP_SC));

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && last_op == OP_SC && !rsp_sc_ok) |=> !cmd_valid);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dly <= DLY_W'(MAX_DELAY));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ST) |-> (cmd_wdata == '0 && !acquired && $past(acquired)));
endmodule

bind lock_backoff_req lbr_checker #(
  .DATA_W(DATA_W), .LOCK_VAL(LOCK_VAL), .MAX_DELAY(MAX_DELAY), .DLY_W(DLY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acquired(acquired), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_sc_ok(rsp_sc_ok), .dly(dly_w)
);

// File: tb/lock_backoff_req_tb.sv
`timescale 1ns/1ps
module lbr_lock_model #(parameter int DW = 8) (
  input  logic          clk,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_sc_ok
);
  int          held_reads, sc_fails, n_ll, n_sc, n_st, idle;
  int          gap [0:63];
  logic [DW-1:0] mem, sc_data, pw;
  logic [1:0]  pop;
  bit          pend;

  task automatic clear();
    held_reads = 0; sc_fails = 0; n_ll = 0; n_sc = 0; n_st = 0;
    idle = 1000; mem = '0; sc_data = '0;
    for (int i = 0; i < 64; i++) gap[i] = -1;
  endtask

  initial begin
    clear();
    pend = 0; pop = 0; pw = '0;
    rsp_valid = 0; rsp_rdata = '0; rsp_sc_ok = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 0; rsp_sc_ok = 0;
      if (pend) begin
        rsp_valid = 1;
        pend = 0;
        case (pop)
          2'd0: begin
            if (held_reads > 0) begin rsp_rdata = DW'(1); held_reads--; end
            else rsp_rdata = mem;
          end
          2'd1: begin
            if (sc_fails > 0) sc_fails--;
            else begin rsp_sc_ok = 1; mem = pw; end
          end
          default: mem = pw;
        endcase
      end
      if (cmd_valid) begin
        pend = 1; pop = cmd_op; pw = cmd_wdata;
        if (cmd_op == 2'd0) begin
          if (n_ll < 64) gap[n_ll] = idle - 1;
          n_ll++;
        end else if (cmd_op == 2'd1) begin
          n_sc++; sc_data = cmd_wdata;
        end else n_st++;
        idle = 0;
      end else idle++;
    end
  end
endmodule

module lock_backoff_req_tb;
  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  logic       acq_req = 0, rel_req = 0, acquired;
  logic       cmd_valid, rsp_valid, rsp_sc_ok;
  logic [1:0] cmd_op;
  logic [7:0] cmd_wdata, rsp_rdata;

  logic       acq2 = 0, acquired2;
  logic       cmd_valid2, rsp_valid2, rsp_sc_ok2;
  logic [1:0] cmd_op2;
  logic [7:0] cmd_wdata2, rsp_rdata2;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  lock_backoff_req u_dut (
    .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .rel_req(rel_req),
    .acquired(acquired), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_sc_ok(rsp_sc_ok)
  );
  lbr_lock_model u_lm (
    .clk(clk), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_sc_ok(rsp_sc_ok)
  );

  lock_backoff_req #(.RAND_INIT(1'b1), .RAND_BITS(2), .LFSR_SEED(8'h3C)) u_rnd (
    .clk(clk), .rst_n(rst_n), .acq_req(acq2), .rel_req(1'b0),
    .acquired(acquired2), .cmd_valid(cmd_valid2), .cmd_op(cmd_op2),
    .cmd_wdata(cmd_wdata2), .rsp_valid(rsp_valid2), .rsp_rdata(rsp_rdata2),
    .rsp_sc_ok(rsp_sc_ok2)
  );
  lbr_lock_model u_lm2 (
    .clk(clk), .cmd_valid(cmd_valid2), .cmd_op(cmd_op2), .cmd_wdata(cmd_wdata2),
    .rsp_valid(rsp_valid2), .rsp_rdata(rsp_rdata2), .rsp_sc_ok(rsp_sc_ok2)
  );

  task automatic at_neg();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic acquire(input string req);
    int t;
    acq_req = 1; at_neg(); acq_req = 0;
    t = 0;
    while (!acquired && t < 3000) begin at_neg(); t++; end
    chk(acquired, req, int'(acquired), 1);
  endtask

  task automatic release_lock();
    rel_req = 1; at_neg(); rel_req = 0;
    repeat (3) at_neg();
  endtask

  task automatic t_reset();
    chk(!acquired, "R1 acquired", int'(acquired), 0);
    chk(!cmd_valid, "R1 cmd_valid", int'(cmd_valid), 0);
  endtask

  task automatic t_uncontended();
    u_lm.clear();
    acq_req = 1; at_neg(); acq_req = 0;
    chk(cmd_valid && cmd_op == 2'd0, "R2 first LL next cycle", int'(cmd_valid), 1);
    at_neg(); at_neg();
    chk(cmd_valid && cmd_op == 2'd1, "R4 SC after free read", int'(cmd_op), 1);
    chk(cmd_wdata == 8'd1, "R4 SC data", int'(cmd_wdata), 1);
    at_neg();
    chk(!acquired, "R5 not yet", int'(acquired), 0);
    at_neg();
    chk(acquired, "R5 acquired", int'(acquired), 1);
    repeat (4) at_neg();
    chk(acquired, "R5 stays held", int'(acquired), 1);
    rel_req = 1; at_neg(); rel_req = 0;
    chk(cmd_valid && cmd_op == 2'd2 && cmd_wdata == 0, "R9 release store", int'(cmd_op), 2);
    chk(!acquired, "R9 acquired drops", int'(acquired), 0);
    repeat (3) at_neg();
    chk(u_lm.n_st == 1 && u_lm.mem == 0, "R9 one store of zero", u_lm.n_st, 1);
  endtask

  task automatic t_held_reads();
    u_lm.clear();
    u_lm.held_reads = 3;
    acquire("R3 acquire");
    chk(u_lm.n_ll == 4, "R3 LL count", u_lm.n_ll, 4);
    for (int i = 1; i < 4; i++) chk(u_lm.gap[i] == 0, "R3 no pause on held", u_lm.gap[i], 0);
    release_lock();
  endtask

  task automatic t_backoff();
    u_lm.clear();
    u_lm.sc_fails = 3;
    acquire("R6 acquire");
    chk(u_lm.gap[1] == 2, "R6 pause 1", u_lm.gap[1], 2);
    chk(u_lm.gap[2] == 4, "R6 pause 2", u_lm.gap[2], 4);
    chk(u_lm.gap[3] == 8, "R6 pause 3", u_lm.gap[3], 8);
    release_lock();
  endtask

  task automatic t_saturate();
    int exp;
    u_lm.clear();
    u_lm.sc_fails = 8;
    acquire("R7 acquire");
    for (int i = 1; i <= 8; i++) begin
      exp = (i >= 6) ? 64 : (1 << i);
      chk(u_lm.gap[i] == exp, "R7 saturating pause", u_lm.gap[i], exp);
    end
    release_lock();
    u_lm.clear();
    u_lm.sc_fails = 1;
    acquire("R8 acquire");
    chk(u_lm.gap[1] == 2, "R8 interval restarts", u_lm.gap[1], 2);
    release_lock();
  endtask

  task automatic t_ignored();
    u_lm.clear();
    rel_req = 1; at_neg(); rel_req = 0;
    repeat (3) at_neg();
    chk(u_lm.n_st == 0 && !cmd_valid, "R10 release while idle", u_lm.n_st, 0);
    u_lm.held_reads = 6;
    acq_req = 1; at_neg(); acq_req = 0;
    repeat (3) at_neg();
    acq_req = 1; rel_req = 1; at_neg(); acq_req = 0; rel_req = 0;
    begin
      int t = 0;
      while (!acquired && t < 500) begin at_neg(); t++; end
    end
    chk(u_lm.n_ll == 7 && u_lm.n_sc == 1, "R10 no extra LL/SC", u_lm.n_ll, 7);
    chk(u_lm.n_st == 0, "R10 no store during acquire", u_lm.n_st, 0);
    acq_req = 1; at_neg(); acq_req = 0;
    repeat (3) at_neg();
    chk(acquired && u_lm.n_ll == 7, "R10 acq while held", u_lm.n_ll, 7);
    release_lock();
  endtask

  task automatic t_random();
    int t, g;
    u_lm2.clear();
    u_lm2.sc_fails = 1;
    acq2 = 1; at_neg(); acq2 = 0;
    t = 0;
    while (!acquired2 && t < 500) begin at_neg(); t++; end
    g = u_lm2.gap[1];
    chk(acquired2 && u_lm2.n_ll == 2, "R11 acquire", u_lm2.n_ll, 2);
    chk(g >= 2 && g <= 8 && (g % 2) == 0, "R11 first pause in range", g, 2);
  endtask

  initial begin
    repeat (3) at_neg();
    t_reset();
    rst_n = 1;
    at_neg();
    t_reset();
    t_uncontended();
    t_held_reads();
    t_backoff();
    t_saturate();
    t_ignored();
    t_random();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule